// File: doc/BRIEF.md
# DRAM Refresh Command Sequencer

This block sits beside the main command scheduler of a DDR3-style memory controller. It takes the command bus over to run a refresh. When one is due it closes any open rows with a precharge and waits out the row precharge time. It then issues a configurable number of REFRESH commands and keeps the bus quiet (NOP only) for the full refresh cycle time after each one. Only then does it return the bus to the scheduler. If no row is open, it skips the precharge and the precharge wait.

Refresh requests that arrive while a sequence is running are counted, up to a fixed maximum, and served one after another. The block also handles self-refresh. On an entry request it closes the rows, drives a REFRESH with the clock enable low, and holds the clock enable low until an exit request arrives. After the exit it holds off writes until the reference voltage has been reported valid for 512 consecutive clocks.

Top module: `rfsh_sequencer`

## Requirements
- R1: After reset, `cmd` is NOP (4'b0111 on {chip select, row strobe, column strobe, write enable}), `cke` is 1, `bus_grant` is 1 and `write_ok` is 1.
- R2: When a refresh or self-refresh entry starts with two or more bits of `bank_open` set, the first command is PRE (4'b0010) with `a10`=1 and `ba`=0.
- R3: When exactly one bit of `bank_open` is set, the PRE carries `a10`=0 and `ba` equal to that bit's index.
- R4: REFRESH (4'b0001) follows the PRE exactly T_RP cycles later, with NOP in between. With no open bank, the REFRESH appears two cycles after a one-cycle `refresh_req` pulse, and no PRE is issued.
- R5: Each request issues NUM_REF REFRESH commands. Each one is followed by T_RFC-1 cycles of NOP, so consecutive REFRESH commands are exactly T_RFC cycles apart.
- R6: `bus_grant` is low from the first PRE or REFRESH of a sequence until T_RFC cycles after the last REFRESH, when it returns high.
- R7: Requests that arrive during a sequence are counted, saturating at PEND_MAX (8), and further requests are dropped. Each counted request runs its own sequence, with one granted NOP cycle between sequences.
- R8: `cke` is 1 in every cycle that drives PRE, and in every cycle that drives a REFRESH other than the self-refresh entry.
- R9: `sr_enter`, sampled while idle with no refresh pending, closes open banks as in R2/R3 and waits T_RP. It then drives REFRESH with `cke`=0, and `cke` stays 0 with NOP and `bus_grant` low until exit.
- R10: `sr_exit` in self-refresh raises `cke` in the next cycle, holds NOP with `bus_grant` low for T_RFC cycles, then grants the bus. `sr_exit` at any other time has no effect on the outputs.
- R11: `write_ok` goes low on self-refresh entry. After exit it returns high only after WR_GATE (512) consecutive cycles with `vref_ok`=1; any cycle with `vref_ok`=0 restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_req | input | 1 | One pulse per refresh due |
| bank_open | input | NUM_BANKS | Per-bank open-row status from the scheduler |
| sr_enter | input | 1 | Self-refresh entry request (level) |
| sr_exit | input | 1 | Self-refresh exit request (level) |
| vref_ok | input | 1 | Reference voltage valid flag |
| cmd | output | 4 | {CS#, RAS#, CAS#, WE#} command while the bus is held |
| a10 | output | 1 | All-bank select for PRE |
| ba | output | log2(NUM_BANKS) | Bank address for single-bank PRE |
| cke | output | 1 | Clock enable |
| bus_grant | output | 1 | High when the main scheduler owns the bus |
| write_ok | output | 1 | High when WRITE commands may be issued |

## Verification
The embedded assertions check every cycle that:
- the `a10` choice matches the bank count of the previous cycle;
- no REFRESH arrives earlier than T_RP after its precharge;
- the post-REFRESH window carries only NOP;
- `cke` is high with PRE and with auto-refresh;
- the pending count never passes its ceiling;
- the write allow never rises without a valid reference.

The exact cycle positions need the bench's scoreboard scenarios:
- the single-bank address, the precharge skip, and the gaps between back-to-back REFRESH commands;
- the single granted cycle between queued sequences, and the number of sequences run when requests saturate;
- the self-refresh exit timing;
- the full 512-cycle write hold, including its restart.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RP,
        ST_RFC,
        ST_SREF,
        ST_XS
    } rfsh_st_e;

    localparam logic [3:0] CMD_DES = 4'b1111;
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_ACT = 4'b0011;

endpackage

// File: rtl/rfsh_bank_pick.sv
module rfsh_bank_pick #(
    parameter int NUM_BANKS = 8,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 any_open,
    output logic                 multi_open,
    output logic [BA_W-1:0]      first_idx
);

    always_comb begin
        any_open   = |bank_open;
        // Clearing the lowest set bit leaves a non-zero value only when more than one bank is open.
        multi_open = |(bank_open & (bank_open - NUM_BANKS'(1)));
        first_idx  = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_open[i]) first_idx = BA_W'(i);
        end
    end

endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
    parameter int PEND_MAX = 8,
    localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pop,
    output logic nz
);

    logic [PEND_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (req && !pop) begin
            if (cnt_q != PEND_W'(PEND_MAX)) cnt_d = cnt_q + 1'b1;
        end else if (!req && pop) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nz = (cnt_q != '0);

    // R7: the count stays within its ceiling
    assert_pend_le_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PEND_W'(PEND_MAX));

    // R7: the sequencer only consumes a request that was counted
    assert_pop_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0);

endmodule

// File: rtl/rfsh_wgate.sv
module rfsh_wgate #(
    parameter int WR_GATE = 512,
    localparam int CNT_W = $clog2(WR_GATE)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic vref_ok,
    output logic write_ok
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (hold) begin
            g_d.armed = 1'b1;
            g_d.cnt   = '0;
        end else if (g_q.armed) begin
            if (!vref_ok) begin
                g_d.cnt = '0;
            end else if (g_q.cnt == CNT_W'(WR_GATE - 1)) begin
                g_d.armed = 1'b0;
                g_d.cnt   = '0;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign write_ok = !g_q.armed;

    // R11: writes are released only after a cycle with a valid reference outside self-refresh
    assert_wr_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_ok) |-> $past(vref_ok) && !$past(hold));

    // R11: self-refresh blocks writes in the following cycle
    assert_wr_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !write_ok);

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer #(
    parameter int NUM_BANKS = 8,
    parameter int T_RP      = 6,
    parameter int T_RFC     = 40,
    parameter int NUM_REF   = 2,
    parameter int PEND_MAX  = 8,
    parameter int WR_GATE   = 512,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_req,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 sr_enter,
    input  logic                 sr_exit,
    input  logic                 vref_ok,
    output logic [3:0]           cmd,
    output logic                 a10,
    output logic [BA_W-1:0]      ba,
    output logic                 cke,
    output logic                 bus_grant,
    output logic                 write_ok
);
    import rfsh_pkg::*;

    localparam int TMAX  = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam int RL_W  = $clog2(NUM_REF + 1);

    typedef struct packed {
        rfsh_st_e         st;
        logic             to_sref;
        logic [TMR_W-1:0] tmr;
        logic [RL_W-1:0]  left;
        logic [3:0]       cmd;
        logic             a10;
        logic [BA_W-1:0]  ba;
        logic             cke;
        logic             grant;
    } regs_t;

    regs_t r_d, r_q;

    logic            any_open, multi_open, pend_nz, pop;
    logic [BA_W-1:0] first_idx;

    rfsh_bank_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
        .bank_open  (bank_open),
        .any_open   (any_open),
        .multi_open (multi_open),
        .first_idx  (first_idx)
    );

    rfsh_pend #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (refresh_req),
        .pop   (pop),
        .nz    (pend_nz)
    );

    rfsh_wgate #(.WR_GATE(WR_GATE)) u_wgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (r_q.st == ST_SREF),
        .vref_ok  (vref_ok),
        .write_ok (write_ok)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        r_d.a10 = 1'b0;
        r_d.ba  = '0;
        pop     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.grant = 1'b1;
                r_d.cke   = 1'b1;
                if (pend_nz || sr_enter) begin
                    r_d.to_sref = !pend_nz;
                    pop         = pend_nz;
                    r_d.grant   = 1'b0;
                    if (any_open) begin
                        r_d.cmd = CMD_PRE;
                        r_d.a10 = multi_open;
                        r_d.ba  = multi_open ? '0 : first_idx;
                        r_d.st  = ST_RP;
                        r_d.tmr = TMR_W'(T_RP - 1);
                    end else begin
                        r_d.cmd = CMD_REF;
                        if (r_d.to_sref) begin
                            r_d.cke = 1'b0;
                            r_d.st  = ST_SREF;
                        end else begin
                            r_d.st   = ST_RFC;
                            r_d.tmr  = TMR_W'(T_RFC - 1);
                            r_d.left = RL_W'(NUM_REF - 1);
                        end
                    end
                end
            end
            ST_RP: begin
                if (r_q.tmr == '0) begin
                    r_d.cmd = CMD_REF;
                    if (r_q.to_sref) begin
                        r_d.cke = 1'b0;
                        r_d.st  = ST_SREF;
                    end else begin
                        r_d.st   = ST_RFC;
                        r_d.tmr  = TMR_W'(T_RFC - 1);
                        r_d.left = RL_W'(NUM_REF - 1);
                    end
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_RFC: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (r_q.left != '0) begin
                    r_d.cmd  = CMD_REF;
                    r_d.tmr  = TMR_W'(T_RFC - 1);
                    r_d.left = r_q.left - 1'b1;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.grant = 1'b1;
                end
            end
            ST_SREF: begin
                r_d.cke = 1'b0;
                if (sr_exit) begin
                    r_d.cke = 1'b1;
                    r_d.st  = ST_XS;
                    r_d.tmr = TMR_W'(T_RFC - 1);
                end
            end
            ST_XS: begin
                if (r_q.tmr == '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.grant = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cmd   <= CMD_NOP;
            r_q.cke   <= 1'b1;
            r_q.grant <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd       = r_q.cmd;
    assign a10       = r_q.a10;
    assign ba        = r_q.ba;
    assign cke       = r_q.cke;
    assign bus_grant = r_q.grant;

    // Checker state: cycles since the last PRE, used for the precharge-gap property.
    logic [TMR_W:0] since_pre_q;
    logic           pre_open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= '0;
            pre_open_q  <= 1'b0;
        end else if (cmd == CMD_PRE) begin
            since_pre_q <= (TMR_W + 1)'(1);
            pre_open_q  <= 1'b1;
        end else begin
            if (since_pre_q != (TMR_W + 1)'(TMAX + 1)) since_pre_q <= since_pre_q + 1'b1;
            if (cmd == CMD_REF) pre_open_q <= 1'b0;
        end
    end

    // R2: several open banks force an all-bank precharge
    assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && $countones($past(bank_open)) > 1) |-> a10);

    // R3: a precharge is only issued when some bank was open
    assert_pre_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |-> $past(bank_open) != '0);

    // R4: refresh never comes earlier than T_RP after its precharge
    assert_rp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && pre_open_q) |-> since_pre_q >= (TMR_W + 1)'(T_RP));

    // R5: quiet window after each refresh
    assert_rfc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RFC && r_q.tmr != TMR_W'(T_RFC - 1)) |-> cmd == CMD_NOP);

    // R6: while granted, the sequencer drives only NOP
    assert_grant_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> cmd == CMD_NOP);

    // R8: clock enable high with precharge
    assert_cke_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |-> cke);

    // R8: a refresh with clock enable low is only the self-refresh entry
    assert_cke_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && !cke) |-> r_q.st == ST_SREF);

endmodule

// File: tb/test_rfsh_sequencer.sv
module test_rfsh_sequencer;
    localparam int TB_RP   = 6;
    localparam int TB_RFC  = 40;
    localparam int TB_NREF = 2;
    localparam int TB_GATE = 512;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_req = 1'b0;
    logic [7:0] bank_open = '0;
    logic       sr_enter = 1'b0;
    logic       sr_exit = 1'b0;
    logic       vref_ok = 1'b0;
    logic [3:0] cmd;
    logic       a10;
    logic [2:0] ba;
    logic       cke;
    logic       bus_grant;
    logic       write_ok;

    always #2ns clk = ~clk;

    rfsh_sequencer #(
        .NUM_BANKS(8), .T_RP(TB_RP), .T_RFC(TB_RFC), .NUM_REF(TB_NREF),
        .PEND_MAX(8), .WR_GATE(TB_GATE)
    ) i_rfsh_sequencer (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .bank_open(bank_open),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .vref_ok(vref_ok),
        .cmd(cmd), .a10(a10), .ba(ba), .cke(cke), .bus_grant(bus_grant), .write_ok(write_ok)
    );

    typedef struct {
        logic [3:0] cmd;
        logic       a10;
        logic [2:0] ba;
        logic       cke;
        logic       grant;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   ref_seen = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t mk(input logic [3:0] c, input logic a, input logic [2:0] b,
                                input logic k, input logic g, input string t);
        exp_t e;
        e.cmd = c; e.a10 = a; e.ba = b; e.cke = k; e.grant = g; e.tag = t;
        return e;
    endfunction

    task automatic push(input exp_t e, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(e);
    endtask

    task automatic push_ref_seq(input string t);
        for (int r = 0; r < TB_NREF; r++) begin
            push(mk(REF, 0, 0, 1, 0, t), 1);
            push(mk(NOP, 0, 0, 1, 0, t), TB_RFC - 1);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares it with the outputs
    always @(negedge clk) begin
        if (cmd == REF) ref_seen++;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({cmd, a10, ba, cke, bus_grant} == {e.cmd, e.a10, e.ba, e.cke, e.grant},
                e.tag, "{cmd,a10,ba,cke,grant}",
                int'({cmd, a10, ba, cke, bus_grant}),
                int'({e.cmd, e.a10, e.ba, e.cke, e.grant}));
        end
    end

    task automatic drive_step;
        @(posedge clk);
        #1ns;
    endtask

    task automatic drain;
        wait (exp_q.size() == 0);
        drive_step();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) drive_step();
        rst_n = 1'b1;
        drive_step();

        // R1: reset state
        chk(cmd == NOP, "R1", "cmd", int'(cmd), int'(NOP));
        chk(cke && bus_grant && write_ok, "R1", "cke/grant/write_ok",
            int'({cke, bus_grant, write_ok}), 7);

        // R2, R4, R5, R6: two open banks -> all-bank precharge
        bank_open   = 8'b0010_0010;
        refresh_req = 1'b1;
        push(mk(NOP, 0, 0, 1, 1, "R6"), 2);
        push(mk(PRE, 1, 0, 1, 0, "R2"), 1);
        push(mk(NOP, 0, 0, 1, 0, "R4"), TB_RP - 1);
        push_ref_seq("R5");
        push(mk(NOP, 0, 0, 1, 1, "R6"), 1);
        drive_step();
        refresh_req = 1'b0;
        drive_step();
        drive_step();
        bank_open = '0;
        drain();

        // R3: one open bank -> single-bank precharge to its index
        bank_open   = 8'b0100_0000;
        refresh_req = 1'b1;
        push(mk(NOP, 0, 0, 1, 1, "R6"), 2);
        push(mk(PRE, 0, 3'd6, 1, 0, "R3"), 1);
        push(mk(NOP, 0, 0, 1, 0, "R4"), TB_RP - 1);
        push_ref_seq("R5");
        push(mk(NOP, 0, 0, 1, 1, "R6"), 1);
        drive_step();
        refresh_req = 1'b0;
        drive_step();
        drive_step();
        bank_open = '0;
        drain();

        // R4, R7: no open bank, four requests -> four sequences with one granted cycle between
        refresh_req = 1'b1;
        push(mk(NOP, 0, 0, 1, 1, "R4"), 2);
        push_ref_seq("R4");
        for (int s = 0; s < 3; s++) begin
            push(mk(NOP, 0, 0, 1, 1, "R7"), 1);
            push_ref_seq("R7");
        end
        push(mk(NOP, 0, 0, 1, 1, "R7"), 1);
        repeat (4) drive_step();
        refresh_req = 1'b0;
        drain();

        // R7: saturation of the pending count at 8
        ref_seen    = 0;
        refresh_req = 1'b1;
        drive_step();
        refresh_req = 1'b0;
        while (bus_grant) drive_step();
        refresh_req = 1'b1;
        repeat (12) drive_step();
        refresh_req = 1'b0;
        repeat (900) drive_step();
        chk(ref_seen == 9 * TB_NREF, "R7", "refresh count after saturation",
            ref_seen, 9 * TB_NREF);
        chk(bus_grant == 1'b1, "R7", "grant after queued sequences", int'(bus_grant), 1);

        // R10: exit request outside self-refresh is ignored
        sr_exit = 1'b1;
        push(mk(NOP, 0, 0, 1, 1, "R10"), 4);
        drive_step();
        sr_exit = 1'b0;
        drain();

        // R9, R3, R8: self-refresh entry with one open bank
        bank_open = 8'b0000_1000;
        sr_enter  = 1'b1;
        push(mk(NOP, 0, 0, 1, 1, "R9"), 1);
        push(mk(PRE, 0, 3'd3, 1, 0, "R9"), 1);
        push(mk(NOP, 0, 0, 1, 0, "R9"), TB_RP - 1);
        push(mk(REF, 0, 0, 0, 0, "R9"), 1);
        push(mk(NOP, 0, 0, 0, 0, "R9"), 6);
        drive_step();
        sr_enter = 1'b0;
        drive_step();
        bank_open = '0;
        drain();
        chk(write_ok == 1'b0, "R11", "write_ok in self-refresh", int'(write_ok), 0);

        // R10: exit timing
        sr_exit = 1'b1;
        push(mk(NOP, 0, 0, 0, 0, "R10"), 1);
        push(mk(NOP, 0, 0, 1, 0, "R10"), TB_RFC);
        push(mk(NOP, 0, 0, 1, 1, "R10"), 1);
        drive_step();
        sr_exit = 1'b0;
        drain();
        chk(write_ok == 1'b0, "R11", "write_ok before reference valid", int'(write_ok), 0);

        // R11: a drop of the reference flag restarts the count
        vref_ok = 1'b1;
        repeat (100) drive_step();
        vref_ok = 1'b0;
        drive_step();
        chk(write_ok == 1'b0, "R11", "write_ok after interrupted count", int'(write_ok), 0);
        vref_ok = 1'b1;
        repeat (TB_GATE - 1) drive_step();
        chk(write_ok == 1'b0, "R11", "write_ok one cycle early", int'(write_ok), 0);
        drive_step();
        chk(write_ok == 1'b1, "R11", "write_ok after full window", int'(write_ok), 1);

        repeat (4) drive_step();
        finish_run();
    end

endmodule